// File: doc/BRIEF.md
# Palette DAC Clock-Synthesizer Register Port

This block models the host-visible register file of a palette DAC that also carries a clock synthesizer. A host reaches it through an 8-bit bus with four register addresses: a mask/command register, a read-index register, a write-index register and a data register. A decode-select input decides what those addresses reach. With the select low, the block acts as a colour lookup table whose entries are red, green and blue byte triplets. With the select high, the same index and data addresses walk the synthesizer coefficient table in M-then-N byte pairs, and the mask address reaches the command register that picks the pixel format.

Each coefficient entry holds a 7-bit M word and a 7-bit N word. The N word packs a 5-bit feedback divider N1 in bits [4:0] and a 2-bit post-divider N2 in bits [6:5]. Two entries are fixed and read-only, so a host can use them to identify the part. Entry 2 is the programmable pixel clock and entry 10 holds the memory clock. All M/N words are driven out in parallel for the clock generator next to the block. An identification byte is returned in place of the mask on the fourth mask read in a row.

Top module: `clksynth_regport`

## Requirements
- R1: Bus address encoding is 0 = mask/command, 1 = read index, 2 = write index, 3 = data. `pll_sel` = 0 selects the palette decode and 1 selects the synthesizer decode. After reset the pixel mask reads 0xFF, the command register and `pix_mode_o` are 0, and both indices read 0.
- R2: A write to address 1 or 2 loads the 8-bit read or write index and restarts its byte phase at the first byte. A read of address 1 or 2 returns the current read or write index.
- R3: In the synthesizer decode, data accesses step through M, then N, then the M of the next entry. Reads return {0, M[6:0]} and {0, N[6:0]}. Bit 7 of a written coefficient byte is dropped.
- R4: Entries 0 and 1 are read-only and read M=0x28, N=0x61 and M=0x3D, N=0x62, so four reads from index 0 give 0x28, 0x61, 0x3D, 0x62. Writes to them are ignored, but the write index still advances.
- R5: Reset loads entry 2 with M=0x7F and N=0x52 (N1=18, N2=2); other writable entries reset to 0. A write to entry e shows on `pll_m_o[e*7 +: 7]` or `pll_n_o[e*7 +: 7]` after the next clock edge.
- R6: A mask-address write with `pll_sel`=1 loads the command register, and with `pll_sel`=0 loads the pixel mask instead. `pix_mode_o` decodes command bits [6:5]: 00 gives 0 (8-bit), 01 gives 1 (15-bit), 11 gives 2 (16-bit), 10 gives 3 (32-bit). A mask read returns the command in the synthesizer decode and the pixel mask in the palette decode.
- R7: In the palette decode each entry is three bytes in red, green, blue order, and the index advances after the third byte. Bytes written from index 0 read back in the same order from read index 0. Palette writes leave the coefficient table untouched.
- R8: The fourth mask read in a row returns the ID byte {0x7, CHIP_REV} (0x72 by default) in either decode. The first three reads return normal data, and the count starts again after the ID read.
- R9: Any bus access other than a mask read (a mask write, or any access to addresses 1 to 3) clears the mask-read count.
- R10: Data reads advance only the read index, and data writes advance only the write index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pll_sel | input | 1 | 0 = palette decode, 1 = synthesizer decode |
| bus_addr | input | 2 | Register address (see R1) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high, 0 otherwise |
| cmd_o | output | 8 | Command register contents |
| pix_mode_o | output | 2 | Decoded pixel format (see R6) |
| pll_m_o | output | PLL_ENTRIES*7 (112) | M words of all entries, entry e at bits e*7 +: 7 |
| pll_n_o | output | PLL_ENTRIES*7 (112) | N words of all entries, entry e at bits e*7 +: 7 |

## Verification
A byte phase that drifts shows on the next data read as an M returned where N is expected, or as a colour byte out of order. A corrupted index shows on the next index read-back. A bad mask-read count shows within four mask reads, as an ID byte that comes too early, too late or never. A write that leaks past the read-only guard, or that reaches the wrong table, shows on the parallel M/N outputs one clock after the data write, with no read needed.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;

    localparam int unsigned COEF_W = 7;

    typedef enum logic [1:0] {
        PORT_MASK = 2'd0,
        PORT_RIDX = 2'd1,
        PORT_WIDX = 2'd2,
        PORT_DATA = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        PIX_8B  = 2'd0,
        PIX_15B = 2'd1,
        PIX_16B = 2'd2,
        PIX_32B = 2'd3
    } pix_mode_e;

    // Fixed identification entries of the coefficient table
    localparam logic [COEF_W-1:0] FIX0_M = 7'h28;
    localparam logic [COEF_W-1:0] FIX0_N = 7'h61;
    localparam logic [COEF_W-1:0] FIX1_M = 7'h3D;
    localparam logic [COEF_W-1:0] FIX1_N = 7'h62;

    // Pixel clock entry and its reset coefficients
    localparam int unsigned        PIXCLK_ENTRY = 2;
    localparam logic [COEF_W-1:0]  PIXCLK_RST_M = 7'h7F;
    localparam logic [COEF_W-1:0]  PIXCLK_RST_N = 7'h52;

    // Last byte phase of an entry in each decode
    localparam logic [1:0] PAIR_LAST    = 2'd1;
    localparam logic [1:0] TRIPLET_LAST = 2'd2;

    localparam logic [3:0] ID_NIBBLE = 4'h7;

endpackage

// File: rtl/clksynth_idx_seq.sv
module clksynth_idx_seq
    import clksynth_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    input  logic             pair_mode,
    output logic [IDX_W-1:0] idx_o,
    output logic [1:0]       phase_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [1:0]       phase;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic [1:0] last_phase;

    always_comb begin
        last_phase = pair_mode ? PAIR_LAST : TRIPLET_LAST;
        seq_d      = seq_q;
        if (load) begin
            seq_d.idx   = load_val;
            seq_d.phase = 2'd0;
        end else if (step) begin
            if (seq_q.phase >= last_phase) begin
                seq_d.phase = 2'd0;
                seq_d.idx   = seq_q.idx + 1'b1;
            end else begin
                seq_d.phase = seq_q.phase + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign idx_o   = seq_q.idx;
    assign phase_o = seq_q.phase;

    // R2: an index load restarts the byte phase
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (seq_q.idx == $past(load_val)) && (seq_q.phase == 2'd0));

    // R3: the N byte of a pair moves on to the next entry
    a_r3_pair_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && pair_mode && seq_q.phase == PAIR_LAST)
        |=> (seq_q.phase == 2'd0) && (seq_q.idx == IDX_W'($past(seq_q.idx) + 1'b1)));

endmodule

// File: rtl/clksynth_coef_bank.sv
module clksynth_coef_bank
    import clksynth_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned SEL_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SEL_W-1:0]          w_sel,
    input  logic                      w_is_n,
    input  logic [COEF_W-1:0]         wdata,
    input  logic [SEL_W-1:0]          r_sel,
    input  logic                      r_is_n,
    output logic [COEF_W-1:0]         rdata,
    output logic [ENTRIES*COEF_W-1:0] m_flat,
    output logic [ENTRIES*COEF_W-1:0] n_flat
);

    typedef struct packed {
        logic [COEF_W-1:0] m;
        logic [COEF_W-1:0] n;
    } coef_t;

    logic [COEF_W-1:0] m_arr [ENTRIES];
    logic [COEF_W-1:0] n_arr [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        if (e == 0) begin : g_fix0
            assign m_arr[e] = FIX0_M;
            assign n_arr[e] = FIX0_N;
        end else if (e == 1) begin : g_fix1
            assign m_arr[e] = FIX1_M;
            assign n_arr[e] = FIX1_N;
        end else begin : g_rw
            localparam logic [COEF_W-1:0] RST_M = (e == PIXCLK_ENTRY) ? PIXCLK_RST_M : '0;
            localparam logic [COEF_W-1:0] RST_N = (e == PIXCLK_ENTRY) ? PIXCLK_RST_N : '0;

            coef_t ent_d, ent_q;

            always_comb begin
                ent_d = ent_q;
                if (we && (w_sel == SEL_W'(e))) begin
                    if (w_is_n) ent_d.n = wdata;
                    else        ent_d.m = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q.m <= RST_M;
                    ent_q.n <= RST_N;
                end else begin
                    ent_q <= ent_d;
                end
            end

            assign m_arr[e] = ent_q.m;
            assign n_arr[e] = ent_q.n;

            // R5: a write to this entry lands in the addressed word
            a_r5_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
                (we && w_sel == SEL_W'(e))
                |=> ($past(w_is_n) ? ent_q.n : ent_q.m) == $past(wdata));
        end

        assign m_flat[e*COEF_W +: COEF_W] = m_arr[e];
        assign n_flat[e*COEF_W +: COEF_W] = n_arr[e];
    end

    assign rdata = r_is_n ? n_arr[r_sel] : m_arr[r_sel];

endmodule

// File: rtl/clksynth_palette.sv
module clksynth_palette #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned SEL_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] w_sel,
    input  logic [1:0]       w_phase,
    input  logic [7:0]       wdata,
    input  logic [SEL_W-1:0] r_sel,
    input  logic [1:0]       r_phase,
    output logic [7:0]       rdata
);

    localparam int unsigned BYTES  = ENTRIES * 3;
    localparam int unsigned ADDR_W = $clog2(BYTES);

    function automatic logic [ADDR_W-1:0] byte_addr(input logic [SEL_W-1:0] s,
                                                    input logic [1:0] p);
        return ADDR_W'(int'(s) * 3 + int'(p));
    endfunction

    logic [7:0] mem_d [BYTES];
    logic [7:0] mem_q [BYTES];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[byte_addr(w_sel, w_phase)] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[byte_addr(r_sel, r_phase)];

    // R7: the colour phase handed to the table never leaves red/green/blue
    a_r7_phase_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (w_phase <= 2'd2));

endmodule

// File: rtl/clksynth_mask_ctl.sv
module clksynth_mask_ctl
    import clksynth_pkg::*;
#(
    parameter logic [3:0] CHIP_REV = 4'h2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_sel,
    input  logic       mask_rd,
    input  logic       mask_wr,
    input  logic       other_acc,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] cmd_o,
    output logic [1:0] pix_mode_o
);

    localparam logic [7:0] ID_BYTE = {ID_NIBBLE, CHIP_REV};
    localparam logic [1:0] ID_SLOT = 2'd3;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] pmask;
        logic [1:0] rd_cnt;
    } mctl_t;

    mctl_t     st_d, st_q;
    pix_mode_e mode;

    always_comb begin
        st_d = st_q;
        if (mask_wr) begin
            if (pll_sel) st_d.cmd   = wdata;
            else         st_d.pmask = wdata;
            st_d.rd_cnt = 2'd0;
        end else if (mask_rd) begin
            st_d.rd_cnt = (st_q.rd_cnt == ID_SLOT) ? 2'd0 : st_q.rd_cnt + 2'd1;
        end else if (other_acc) begin
            st_d.rd_cnt = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd    <= 8'h00;
            st_q.pmask  <= 8'hFF;
            st_q.rd_cnt <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.cmd[6:5])
            2'b00:   mode = PIX_8B;
            2'b01:   mode = PIX_15B;
            2'b11:   mode = PIX_16B;
            default: mode = PIX_32B;
        endcase
    end

    always_comb begin
        if (st_q.rd_cnt == ID_SLOT) rdata = ID_BYTE;
        else if (pll_sel)           rdata = st_q.cmd;
        else                        rdata = st_q.pmask;
    end

    assign cmd_o      = st_q.cmd;
    assign pix_mode_o = mode;

    // R6: a command write in the synthesizer decode is captured
    a_r6_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && pll_sel) |=> cmd_o == $past(wdata));

    // R6: a mask write in the palette decode leaves the command alone
    a_r6_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !pll_sel) |=> $stable(cmd_o));

    // R9: any other access restarts the mask-read count
    a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((other_acc || mask_wr) && !mask_rd) |=> st_q.rd_cnt == 2'd0);

    // R8: four mask reads in a row from a cleared count give the ID byte
    a_r8_id_fourth: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd && $past(mask_rd) && $past(mask_rd, 2) && $past(mask_rd, 3)
         && !$past(mask_wr) && !$past(mask_wr, 2) && !$past(mask_wr, 3)
         && ($past(st_q.rd_cnt, 3) == 2'd0)) |-> rdata == ID_BYTE);

endmodule

// File: rtl/clksynth_regport.sv
module clksynth_regport
    import clksynth_pkg::*;
#(
    parameter int unsigned PLL_ENTRIES = 16,
    parameter int unsigned LUT_ENTRIES = 16,
    parameter logic [3:0]  CHIP_REV    = 4'h2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pll_sel,
    input  logic [1:0]                    bus_addr,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [7:0]                    bus_wdata,
    output logic [7:0]                    bus_rdata,
    output logic [7:0]                    cmd_o,
    output logic [1:0]                    pix_mode_o,
    output logic [PLL_ENTRIES*COEF_W-1:0] pll_m_o,
    output logic [PLL_ENTRIES*COEF_W-1:0] pll_n_o
);

    localparam int unsigned IDX_W   = 8;
    localparam int unsigned PSEL_W  = $clog2(PLL_ENTRIES);
    localparam int unsigned LSEL_W  = $clog2(LUT_ENTRIES);

    port_e addr;
    assign addr = port_e'(bus_addr);

    // Access decode
    logic acc_mask_rd, acc_mask_wr, acc_other;
    logic rix_load, wix_load, data_rd, data_wr;

    always_comb begin
        acc_mask_rd = bus_rd && (addr == PORT_MASK);
        acc_mask_wr = bus_wr && (addr == PORT_MASK);
        acc_other   = (bus_rd || bus_wr) && (addr != PORT_MASK);
        rix_load    = bus_wr && (addr == PORT_RIDX);
        wix_load    = bus_wr && (addr == PORT_WIDX);
        data_rd     = bus_rd && (addr == PORT_DATA);
        data_wr     = bus_wr && (addr == PORT_DATA);
    end

    logic [IDX_W-1:0] r_idx, w_idx;
    logic [1:0]       r_ph,  w_ph;

    clksynth_idx_seq #(.IDX_W(IDX_W)) u_rd_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rix_load),
        .load_val (bus_wdata),
        .step     (data_rd),
        .pair_mode(pll_sel),
        .idx_o    (r_idx),
        .phase_o  (r_ph)
    );

    clksynth_idx_seq #(.IDX_W(IDX_W)) u_wr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wix_load),
        .load_val (bus_wdata),
        .step     (data_wr),
        .pair_mode(pll_sel),
        .idx_o    (w_idx),
        .phase_o  (w_ph)
    );

    logic [COEF_W-1:0] coef_rdata;

    clksynth_coef_bank #(.ENTRIES(PLL_ENTRIES)) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (data_wr && pll_sel),
        .w_sel  (w_idx[PSEL_W-1:0]),
        .w_is_n (w_ph[0]),
        .wdata  (bus_wdata[COEF_W-1:0]),
        .r_sel  (r_idx[PSEL_W-1:0]),
        .r_is_n (r_ph[0]),
        .rdata  (coef_rdata),
        .m_flat (pll_m_o),
        .n_flat (pll_n_o)
    );

    logic [7:0] lut_rdata;

    clksynth_palette #(.ENTRIES(LUT_ENTRIES)) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (data_wr && !pll_sel),
        .w_sel   (w_idx[LSEL_W-1:0]),
        .w_phase (w_ph),
        .wdata   (bus_wdata),
        .r_sel   (r_idx[LSEL_W-1:0]),
        .r_phase (r_ph),
        .rdata   (lut_rdata)
    );

    logic [7:0] mask_rdata;

    clksynth_mask_ctl #(.CHIP_REV(CHIP_REV)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_sel    (pll_sel),
        .mask_rd    (acc_mask_rd),
        .mask_wr    (acc_mask_wr),
        .other_acc  (acc_other),
        .wdata      (bus_wdata),
        .rdata      (mask_rdata),
        .cmd_o      (cmd_o),
        .pix_mode_o (pix_mode_o)
    );

    // Read data return
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            unique case (addr)
                PORT_MASK: bus_rdata = mask_rdata;
                PORT_RIDX: bus_rdata = r_idx;
                PORT_WIDX: bus_rdata = w_idx;
                default:   bus_rdata = pll_sel ? {1'b0, coef_rdata} : lut_rdata;
            endcase
        end
    end

    // R10: data reads never move the write pointer
    a_r10_rd_keeps_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !bus_wr) |=> $stable(w_idx) && $stable(w_ph));

    // R10: data writes never move the read pointer
    a_r10_wr_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !bus_rd) |=> $stable(r_idx) && $stable(r_ph));

    // R3: synthesizer data reads clear the top bit
    a_r3_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && pll_sel) |-> !bus_rdata[7]);

endmodule

// File: tb/tb_clksynth_regport.sv
module tb_clksynth_regport;

    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_sel = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [7:0]    cmd_o;
    logic [1:0]    pix_mode_o;
    logic [NE*7-1:0] pll_m_o, pll_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [1:0] A_MASK = 2'd0, A_RIDX = 2'd1, A_WIDX = 2'd2, A_DATA = 2'd3;
    localparam logic [7:0] ID_EXP = 8'h72;

    always #10 clk = ~clk;

    clksynth_regport dut (
        .clk(clk), .rst_n(rst_n), .pll_sel(pll_sel), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_o(cmd_o), .pix_mode_o(pix_mode_o), .pll_m_o(pll_m_o), .pll_n_o(pll_n_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic logic [6:0] m_of(input int e);
        return pll_m_o[e*7 +: 7];
    endfunction
    function automatic logic [6:0] n_of(input int e);
        return pll_n_o[e*7 +: 7];
    endfunction

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 cmd reset", cmd_o, 8'h00);
        chk("R1 mode reset", pix_mode_o, 2'd0);
        chk("R5 entry2 M reset", m_of(2), 7'h7F);
        chk("R5 entry2 N reset", n_of(2), 7'h52);
        chk("R4 entry0 M out", m_of(0), 7'h28);
        chk("R4 entry1 N out", n_of(1), 7'h62);
        brd(A_RIDX, d); chk("R2 read index reset", d, 8'h00);
        brd(A_WIDX, d); chk("R2 write index reset", d, 8'h00);
        brd(A_MASK, d); chk("R1 pixel mask reset", d, 8'hFF);
    endtask

    task automatic t_fixed_entries;
        logic [7:0] d;
        logic [7:0] exp [4] = '{8'h28, 8'h61, 8'h3D, 8'h62};
        pll_sel = 1'b1;
        bwr(A_WIDX, 8'h00);
        for (int i = 0; i < 4; i++) bwr(A_DATA, 8'h11);
        brd(A_WIDX, d); chk("R4 write index advanced past fixed entries", d, 8'h02);
        bwr(A_RIDX, 8'h00);
        for (int i = 0; i < 4; i++) begin
            brd(A_DATA, d); chk("R4 fixed entry byte", d, exp[i]);
        end
        chk("R4 entry0 M unchanged", m_of(0), 7'h28);
        chk("R4 entry1 M unchanged", m_of(1), 7'h3D);
    endtask

    task automatic t_coef_prog;
        logic [7:0] d;
        pll_sel = 1'b1;
        bwr(A_WIDX, 8'h02);
        bwr(A_DATA, 8'hA5);
        bwr(A_DATA, 8'h8B);
        bwr(A_DATA, 8'h14);
        chk("R5 entry2 M out", m_of(2), 7'h25);
        chk("R5 entry2 N out", n_of(2), 7'h0B);
        chk("R5 entry3 M out", m_of(3), 7'h14);
        bwr(A_RIDX, 8'h02);
        brd(A_DATA, d); chk("R3 M read masked", d, 8'h25);
        brd(A_DATA, d); chk("R3 N read masked", d, 8'h0B);
        brd(A_DATA, d); chk("R3 next entry M", d, 8'h14);
        brd(A_RIDX, d); chk("R2 read index after 3 bytes", d, 8'h03);
        bwr(A_WIDX, 8'h0A);
        bwr(A_DATA, 8'h33);
        bwr(A_DATA, 8'h45);
        chk("R5 entry10 M out", m_of(10), 7'h33);
        chk("R3 entry10 N1 field", n_of(10) & 7'h1F, 7'h05);
        chk("R3 entry10 N2 field", n_of(10) >> 5, 7'h02);
    endtask

    task automatic t_command;
        logic [7:0] d;
        pll_sel = 1'b1;
        bwr(A_MASK, 8'h20); chk("R6 15-bit mode", pix_mode_o, 2'd1);
        bwr(A_MASK, 8'h60); chk("R6 16-bit mode", pix_mode_o, 2'd2);
        chk("R6 command value", cmd_o, 8'h60);
        bwr(A_MASK, 8'h40); chk("R6 32-bit mode", pix_mode_o, 2'd3);
        brd(A_MASK, d); chk("R6 command read back", d, 8'h40);
        bwr(A_MASK, 8'h00); chk("R6 8-bit mode", pix_mode_o, 2'd0);
        pll_sel = 1'b0;
        bwr(A_MASK, 8'h5A);
        chk("R6 palette mask write keeps command", cmd_o, 8'h00);
        brd(A_MASK, d); chk("R6 pixel mask read back", d, 8'h5A);
    endtask

    task automatic t_palette;
        logic [7:0] d;
        pll_sel = 1'b0;
        bwr(A_WIDX, 8'h00);
        for (int i = 0; i < 6; i++) bwr(A_DATA, 8'(8'h10 * (i + 1) + 1));
        brd(A_WIDX, d); chk("R7 write index after two triplets", d, 8'h02);
        bwr(A_RIDX, 8'h00);
        for (int i = 0; i < 6; i++) begin
            brd(A_DATA, d); chk("R7 palette byte order", d, 8'(8'h10 * (i + 1) + 1));
        end
        brd(A_WIDX, d); chk("R10 data reads keep write index", d, 8'h02);
        brd(A_RIDX, d); chk("R10 read index after six reads", d, 8'h02);
        chk("R7 palette writes keep entry2 M", m_of(2), 7'h25);
    endtask

    task automatic t_chip_id;
        logic [7:0] d;
        pll_sel = 1'b0;
        bwr(A_WIDX, 8'h00);
        for (int i = 0; i < 3; i++) begin
            brd(A_MASK, d); chk("R8 normal mask read", d, 8'h5A);
        end
        brd(A_MASK, d); chk("R8 fourth read gives ID", d, ID_EXP);
        brd(A_MASK, d); chk("R8 count restarts after ID", d, 8'h5A);
        pll_sel = 1'b1;
        bwr(A_RIDX, 8'h00);
        for (int i = 0; i < 3; i++) brd(A_MASK, d);
        brd(A_MASK, d); chk("R8 ID in synthesizer decode", d, ID_EXP);
        pll_sel = 1'b0;
    endtask

    task automatic t_count_clear;
        logic [7:0] d;
        pll_sel = 1'b0;
        bwr(A_WIDX, 8'h00);
        brd(A_MASK, d);
        brd(A_MASK, d);
        brd(A_RIDX, d);
        for (int i = 0; i < 3; i++) brd(A_MASK, d);
        chk("R9 index read clears count", d, 8'h5A);
        brd(A_MASK, d); chk("R9 ID after fresh run", d, ID_EXP);
        for (int i = 0; i < 3; i++) brd(A_MASK, d);
        bwr(A_MASK, 8'h5A);
        brd(A_MASK, d); chk("R9 mask write clears count", d, 8'h5A);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_fixed_entries();
        t_coef_prog();
        t_command();
        t_palette();
        t_chip_id();
        t_count_clear();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule